// File: doc/BRIEF.md
# Low-Power Wakeup Pin Debouncer

This block qualifies two external wakeup pins before they may wake the system. Each pin goes through a synchroniser into the slow clock domain. A per-pin counter then measures how long the pin stays high. The unit of that measurement is not the block's own clock but a separate low-rate reference. Its periods arrive as single-cycle `ref_tick` strobes. A 3-bit period select sets the required hold time as the select value plus one reference periods. A select of zero switches the debouncing off for both pins.

Once a pin has held long enough, its event flag goes high and the block asserts a wakeup request. If clear-on-event is enabled, the block also issues a single-cycle request to erase the lower half of a backup register file. The flag stays up while the pin remains active. The pin must drop and qualify again before a new event or erase request can appear. The tick generator, the backup registers and any register access sit outside this block.

Top module: `lp_wake_debounce`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `wake_req`, both bits of `evt_flag` and `erase_pulse` are 0.
- R2: With `period_sel` equal to 0, no pin produces an event, a wakeup or an erase request. Setting `period_sel` to 0 while a flag is high clears it on the next clock edge.
- R3: A pin with `period_sel` = S (1..7) qualifies on the clock edge that samples its (S+1)-th `ref_tick` while it is continuously high after its two-flop synchroniser. After S ticks it has not qualified. Clock cycles without a tick do not count.
- R4: Bit i of `pin_en` gates pin i (bit 0 is the first pin). While the bit is 0, that pin does not count and raises no event. Counting starts with the first tick after the bit is set.
- R5: `evt_flag[i]` rises once per qualification and stays high while the pin stays active and enabled. It gives no further erase request. After the pin has gone low, a new qualification raises it again. `wake_req` is high exactly when any event flag is high.
- R6: A pin that goes low, as seen after the synchroniser, before it qualifies loses its accumulated count. It needs a full S+1 ticks after it returns high.
- R7: With `erase_on_evt` = 1, `erase_pulse` is high for exactly the one cycle in which an event flag rises. With `erase_on_evt` = 0, `erase_pulse` stays 0.
- R8: When both pins qualify on the same edge, only one single-cycle `erase_pulse` results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe marking a reference period |
| pin_raw | input | 2 | Raw wakeup pin levels, active high, asynchronous |
| period_sel | input | 3 | Hold time select, 0 = off, S = S+1 reference periods |
| pin_en | input | 2 | Per-pin debouncer enable |
| erase_on_evt | input | 1 | Enables the erase request on a qualified event |
| wake_req | output | 1 | System wakeup request |
| evt_flag | output | 2 | Per-pin qualified event flag |
| erase_pulse | output | 1 | One-cycle request to erase the lower half of the backup registers |

## Verification
On every cycle, the bound checker ensures the following. No flag is high one cycle after the select was zero or after the pin's enable was low. A flag or the wakeup request only rises on an edge that sampled a tick. An erase pulse appears only when clear-on-event was set and coincides with a rising flag. The exact hold count (S versus S+1 ticks) is shown only by the bench's scenarios. The same holds for the loss of the count across a gap, for re-qualification after release, and for the merge of a simultaneous two-pin event into one erase pulse.

// File: rtl/wkdb_pkg.sv
package wkdb_pkg;

   // Qualifier state per pin
   typedef enum logic [1:0] {
      QS_IDLE = 2'd0,
      QS_RUN  = 2'd1,
      QS_DONE = 2'd2
   } qual_state_e;

   // Number of reference periods demanded by a select value
   function automatic int unsigned hold_periods(input int unsigned sel);
      return sel + 1;
   endfunction

endpackage

// File: rtl/wkdb_sync.sv
module wkdb_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES > 4) begin : g_bad_stages
      $error("wkdb_sync: STAGES must be at most 4");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_sync = d_async;
   end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ff_q <= '0;
         end else if (STAGES == 1) begin
            ff_q <= d_async;
         end else begin
            ff_q <= {ff_q[STAGES-2:0], d_async};
         end
      end
      assign q_sync = ff_q[STAGES-1];
   end

endmodule

// File: rtl/wkdb_pin_qual.sv
module wkdb_pin_qual
   import wkdb_pkg::*;
#(
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_s,
   input  logic             pin_en,
   input  logic             ref_tick,
   input  logic [SEL_W-1:0] period_sel,
   output logic             hit,
   output logic             qualified
);

   localparam int unsigned CNT_W = SEL_W + 1;

   qual_state_e      state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             armed;

   assign armed = pin_s & pin_en & (period_sel != '0);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      hit     = 1'b0;
      if (!armed) begin
         state_d = QS_IDLE;
         cnt_d   = '0;
      end else begin
         unique case (state_q)
            QS_IDLE, QS_RUN: begin
               if (ref_tick) begin
                  if (cnt_q >= {1'b0, period_sel}) begin
                     hit     = 1'b1;
                     state_d = QS_DONE;
                  end else begin
                     cnt_d   = cnt_q + 1'b1;
                     state_d = QS_RUN;
                  end
               end
            end
            QS_DONE: begin
               state_d = QS_DONE;
            end
            default: begin
               state_d = QS_IDLE;
               cnt_d   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= QS_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign qualified = (state_q == QS_DONE);

endmodule

// File: rtl/wkdb_evt_merge.sv
module wkdb_evt_merge #(
   parameter int unsigned NUM_PINS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] hit_vec,
   input  logic [NUM_PINS-1:0] qual_vec,
   input  logic                erase_en,
   output logic                wake_req,
   output logic [NUM_PINS-1:0] evt_flag,
   output logic                erase_pulse
);

   logic erase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         erase_q <= 1'b0;
      end else begin
         erase_q <= erase_en & (|hit_vec);
      end
   end

   assign evt_flag    = qual_vec;
   assign wake_req    = |qual_vec;
   assign erase_pulse = erase_q;

endmodule

// File: rtl/lp_wake_debounce.sv
module lp_wake_debounce #(
   parameter int unsigned NUM_PINS    = 2,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ref_tick,
   input  logic [NUM_PINS-1:0] pin_raw,
   input  logic [SEL_W-1:0]    period_sel,
   input  logic [NUM_PINS-1:0] pin_en,
   input  logic                erase_on_evt,
   output logic                wake_req,
   output logic [NUM_PINS-1:0] evt_flag,
   output logic                erase_pulse
);

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("lp_wake_debounce: NUM_PINS must be at least 1");
   end
   if (SEL_W < 1 || SEL_W > 8) begin : g_bad_sel
      $error("lp_wake_debounce: SEL_W must be in 1..8");
   end

   logic [NUM_PINS-1:0] pin_s;
   logic [NUM_PINS-1:0] hit_vec;
   logic [NUM_PINS-1:0] qual_vec;

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      wkdb_sync #(
         .STAGES (SYNC_STAGES)
      ) i_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .d_async (pin_raw[g]),
         .q_sync  (pin_s[g])
      );

      wkdb_pin_qual #(
         .SEL_W (SEL_W)
      ) i_qual (
         .clk        (clk),
         .rst_n      (rst_n),
         .pin_s      (pin_s[g]),
         .pin_en     (pin_en[g]),
         .ref_tick   (ref_tick),
         .period_sel (period_sel),
         .hit        (hit_vec[g]),
         .qualified  (qual_vec[g])
      );
   end

   wkdb_evt_merge #(
      .NUM_PINS (NUM_PINS)
   ) i_merge (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_vec     (hit_vec),
      .qual_vec    (qual_vec),
      .erase_en    (erase_on_evt),
      .wake_req    (wake_req),
      .evt_flag    (evt_flag),
      .erase_pulse (erase_pulse)
   );

endmodule

// File: rtl/lp_wake_debounce_chk.sv
module lp_wake_debounce_chk #(
   parameter int unsigned NUM_PINS = 2,
   parameter int unsigned SEL_W    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ref_tick,
   input logic [SEL_W-1:0]    period_sel,
   input logic [NUM_PINS-1:0] pin_en,
   input logic                erase_on_evt,
   input logic                wake_req,
   input logic [NUM_PINS-1:0] evt_flag,
   input logic                erase_pulse
);

   AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(period_sel) == '0) |-> (evt_flag == '0)); // R2

   AST_WAKE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_req) |-> $past(ref_tick)); // R3

   AST_ERASE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      erase_pulse |-> $past(erase_on_evt)); // R7

   AST_ERASE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      erase_pulse |-> (|(evt_flag & ~$past(evt_flag)))); // R7

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_chk
      AST_DISABLED_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(pin_en[g]) |-> !evt_flag[g]); // R4

      AST_FLAG_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(evt_flag[g]) |-> ($past(ref_tick) && $past(pin_en[g]))); // R3
   end

endmodule

bind lp_wake_debounce lp_wake_debounce_chk #(
   .NUM_PINS (NUM_PINS),
   .SEL_W    (SEL_W)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ref_tick     (ref_tick),
   .period_sel   (period_sel),
   .pin_en       (pin_en),
   .erase_on_evt (erase_on_evt),
   .wake_req     (wake_req),
   .evt_flag     (evt_flag),
   .erase_pulse  (erase_pulse)
);

// File: tb/test_lp_wake_debounce.sv
`timescale 1ns/1ps
module test_lp_wake_debounce;

   localparam int NP = 2;
   localparam int SW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ref_tick;
   logic [NP-1:0] pin_raw;
   logic [SW-1:0] period_sel;
   logic [NP-1:0] pin_en;
   logic          erase_on_evt;
   logic          wake_req;
   logic [NP-1:0] evt_flag;
   logic          erase_pulse;

   always #2.5 clk = ~clk;

   lp_wake_debounce #(.NUM_PINS(NP), .SEL_W(SW), .SYNC_STAGES(2)) i_lp_wake_debounce (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pin_raw(pin_raw),
      .period_sel(period_sel), .pin_en(pin_en), .erase_on_evt(erase_on_evt),
      .wake_req(wake_req), .evt_flag(evt_flag), .erase_pulse(erase_pulse)
   );

   typedef struct {
      string         req;
      logic          wake;
      logic [NP-1:0] flags;
      logic          erase;
   } exp_t;

   exp_t sbq[$];
   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;

   // Driver side: push an expectation for the current (negedge) sample point
   task automatic expect_out(string req, logic w, logic [NP-1:0] f, logic e);
      exp_t it;
      it.req = req; it.wake = w; it.flags = f; it.erase = e;
      sbq.push_back(it);
      wait (sbq.size() == 0);
   endtask

   // Monitor: pop and compare against the design outputs
   initial begin
      forever begin
         exp_t it;
         wait (sbq.size() != 0);
         it = sbq.pop_front();
         checks++;
         if (wake_req !== it.wake || evt_flag !== it.flags || erase_pulse !== it.erase) begin
            errors++;
            $display("FAIL %s: wake=%0b flags=%b erase=%0b expected wake=%0b flags=%b erase=%0b",
                     it.req, wake_req, evt_flag, erase_pulse, it.wake, it.flags, it.erase);
         end
      end
   end

   task automatic cyc(bit tk);
      ref_tick = tk;
      @(negedge clk);
      ref_tick = 1'b0;
   endtask

   task automatic ticks(int n);
      for (int k = 0; k < n; k++) cyc(1'b1);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) cyc(1'b0);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ref_tick = 1'b0; pin_raw = '0; period_sel = '0;
      pin_en = '0; erase_on_evt = 1'b0;
      repeat (3) @(negedge clk);
      expect_out("R1 in reset", 1'b0, 2'b00, 1'b0);
      rst_n = 1'b1;
      cyc(1'b0);
      expect_out("R1 after reset", 1'b0, 2'b00, 1'b0);

      // R2: select 0 disables both pins
      period_sel = 3'd0; pin_en = 2'b11; erase_on_evt = 1'b1; pin_raw = 2'b11;
      idle(2); ticks(12);
      expect_out("R2 select zero", 1'b0, 2'b00, 1'b0);
      pin_raw = 2'b00; erase_on_evt = 1'b0; idle(4);

      // R3/R7: select 3 needs 4 ticks, no erase when disabled
      period_sel = 3'd3; pin_en = 2'b01; pin_raw = 2'b01;
      idle(2); ticks(3);
      expect_out("R3 after S ticks", 1'b0, 2'b00, 1'b0);
      cyc(1'b1);
      expect_out("R3 R7 qualified no erase", 1'b1, 2'b01, 1'b0);
      ticks(5);
      expect_out("R5 flag held", 1'b1, 2'b01, 1'b0);
      pin_raw = 2'b00; idle(4);
      expect_out("R5 flag drops on release", 1'b0, 2'b00, 1'b0);

      // R4: disabled pin ignored, then enabled
      pin_en = 2'b01; pin_raw = 2'b10;
      idle(2); ticks(10);
      expect_out("R4 disabled pin", 1'b0, 2'b00, 1'b0);
      pin_en = 2'b11; ticks(3);
      expect_out("R4 counting after enable", 1'b0, 2'b00, 1'b0);
      cyc(1'b1);
      expect_out("R4 enabled pin qualifies", 1'b1, 2'b10, 1'b0);
      pin_raw = 2'b00; idle(4);

      // R6: gap restarts the count
      period_sel = 3'd2; pin_en = 2'b10; pin_raw = 2'b10;
      idle(2); ticks(2);
      pin_raw = 2'b00; idle(3);
      pin_raw = 2'b10; idle(2); ticks(2);
      expect_out("R6 count lost across gap", 1'b0, 2'b00, 1'b0);
      cyc(1'b1);
      expect_out("R6 full count after gap", 1'b1, 2'b10, 1'b0);
      pin_raw = 2'b00; idle(4);

      // R7/R8: both pins together, single erase pulse
      erase_on_evt = 1'b1; period_sel = 3'd1; pin_en = 2'b11; pin_raw = 2'b11;
      idle(2); cyc(1'b1);
      expect_out("R3 one tick short", 1'b0, 2'b00, 1'b0);
      cyc(1'b1);
      expect_out("R7 R8 joint erase pulse", 1'b1, 2'b11, 1'b1);
      cyc(1'b0);
      expect_out("R8 single pulse", 1'b1, 2'b11, 1'b0);
      ticks(3);
      expect_out("R5 no repeat erase", 1'b1, 2'b11, 1'b0);
      pin_raw = 2'b00; idle(4);
      expect_out("R5 released", 1'b0, 2'b00, 1'b0);
      pin_raw = 2'b01; idle(2); ticks(2);
      expect_out("R5 requalify erases again", 1'b1, 2'b01, 1'b1);
      cyc(1'b0);
      expect_out("R7 pulse one cycle", 1'b1, 2'b01, 1'b0);
      pin_raw = 2'b00; erase_on_evt = 1'b0; idle(4);

      // R3: sparse ticks with select 7, then R2 turn-off
      period_sel = 3'd7; pin_en = 2'b01; pin_raw = 2'b01;
      idle(2);
      for (int k = 0; k < 7; k++) begin cyc(1'b1); cyc(1'b0); end
      expect_out("R3 seven sparse ticks", 1'b0, 2'b00, 1'b0);
      cyc(1'b1);
      expect_out("R3 eighth tick qualifies", 1'b1, 2'b01, 1'b0);
      period_sel = 3'd0; cyc(1'b0);
      expect_out("R2 select zero clears flag", 1'b0, 2'b00, 1'b0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule